// File: doc/BRIEF.md
# First-Update Checkpoint Block Logger

This block builds the undo log for one checkpoint interval. It sits beside a cache or memory controller and sees every block-granular update or transfer as a request. Each request carries the block's physical address and the 64-byte value the block held before the change. The first time a given block frame is touched after a checkpoint begins, the block captures that old value together with the address into a log FIFO. Later touches of the same frame in the same interval pass straight through without producing an entry. The log drains through a valid/ready stream at whatever rate the downstream writer allows.

Each tracked frame has one "already logged" bit. A checkpoint-start strobe launches a sweep that clears one frame bit per clock. While the sweep runs, the block holds off new requests. When the FIFO is full, a request that would need a log entry is stalled rather than dropped. A request to a frame that is already logged is still accepted, because it needs no space. Entries leave in the order they were captured. A restore process must therefore apply them from newest to oldest.

Top module: `ckpt_undo_logger`

## Requirements
- R1: After reset, log_valid and ckpt_busy are 0, req_ready is 1, and every frame counts as not yet logged, so the first accepted request to any frame produces an entry.
- R2: An accepted request to a frame whose bit is clear pushes one entry. The entry's low DATA_W bits are req_old_data, and the 64 bits above them are req_addr zero-extended, with the address unchanged including its block-offset bits. The frame's bit is then set.
- R3: An accepted request to a frame whose bit is already set in the current interval is consumed (req_ready 1) and pushes no entry.
- R4: After a checkpoint sweep finishes, every frame counts as not logged again, so a frame logged before the checkpoint is logged once more on its next request.
- R5: ckpt_busy is 1 for exactly FRAMES cycles, starting the cycle after the cycle in which ckpt_start is high. req_ready is 0 in the cycle ckpt_start is high and in every busy cycle. A start during a sweep restarts the count.
- R6: Outside a sweep, when the FIFO holds DEPTH entries, req_ready is 0 for a request to a frame whose bit is clear, and 1 for a request to a frame whose bit is set. A stalled request is logged once space frees. A pop in the same cycle does not free space for that cycle.
- R7: Entries leave in acceptance order. While log_valid is 1 and log_ready is 0, log_valid stays 1 and log_entry holds its value.
- R8: log_valid is 1 exactly when the FIFO is non-empty. An entry pushed at a clock edge is visible on log_entry right after that edge.
- R9: The frame index is req_addr bits [OFF_W+IDX_W-1:OFF_W], where OFF_W is log2 of BLOCK_BYTES and IDX_W is log2 of FRAMES. Logging one frame does not mark any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckpt_start | input | 1 | One-cycle strobe opening a new checkpoint interval |
| ckpt_busy | output | 1 | Frame-bit clearing sweep in progress |
| req_valid | input | 1 | Update or transfer request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Physical byte address of the block |
| req_old_data | input | DATA_W | Block contents before the update |
| log_valid | output | 1 | Log entry available |
| log_ready | input | 1 | Downstream takes the entry |
| log_entry | output | 64+DATA_W | {zero-extended address, old data} |

## Verification
Every frame of a small configuration is written once and then rewritten in the same interval. The once-only capture must produce exactly one entry per frame with the exact address and old data, which separates it from logging every write or logging none. A checkpoint strobe is issued while a request is pending, and the busy cycles are counted. Re-logging of a frame that was logged before the strobe shows that the sweep really clears the bits. The FIFO is filled with the output stalled, so that a fresh frame is refused while a repeat frame is still taken. A strided access pattern with a mid-run checkpoint and intermittent output backpressure then compares every entry against an arithmetic model.

// File: rtl/ckpt_log_pkg.sv
package ckpt_log_pkg;
  localparam int unsigned LOG_ADDR_W = 64;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned next_wrap(input int unsigned v, input int unsigned n);
    return (v == n - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/ckpt_flag_array.sv
module ckpt_flag_array
  import ckpt_log_pkg::*;
#(
  parameter int unsigned FRAMES = 64,
  localparam int unsigned IDX_W = idx_bits(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_start,
  input  logic [IDX_W-1:0] look_idx,
  input  logic             mark,
  output logic             hit,
  output logic             sweep_busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [FRAMES-1:0] flags_q;
  logic [IDX_W-1:0]  sweep_idx;
  logic              sweep_last;

  assign sweep_last = (sweep_idx == LAST);
  assign hit        = flags_q[look_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q    <= '0;
      sweep_busy <= 1'b0;
      sweep_idx  <= '0;
    end else if (sweep_start) begin
      sweep_busy <= 1'b1;
      sweep_idx  <= '0;
    end else if (sweep_busy) begin
      flags_q[sweep_idx] <= 1'b0;
      sweep_idx  <= IDX_W'(next_wrap(int'(sweep_idx), FRAMES));
      if (sweep_last) sweep_busy <= 1'b0;
    end else if (mark) begin
      flags_q[look_idx] <= 1'b1;
    end
  end

  // R4
  sweep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_busy) |-> (flags_q == '0));

  // R5
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && sweep_last && !sweep_start) |=> !sweep_busy);

  // R9
  mark_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !sweep_busy && !sweep_start && !hit) |=>
      ($countones(flags_q) == $countones($past(flags_q)) + 1));
endmodule

// File: rtl/ckpt_log_fifo.sv
module ckpt_log_fifo
  import ckpt_log_pkg::*;
#(
  parameter int unsigned WIDTH = 576,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = idx_bits(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(next_wrap(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(next_wrap(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ckpt_undo_logger.sv
module ckpt_undo_logger
  import ckpt_log_pkg::*;
#(
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned DATA_W      = 512,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned FRAMES      = 64,
  parameter int unsigned DEPTH       = 8,
  localparam int unsigned OFF_W   = idx_bits(BLOCK_BYTES),
  localparam int unsigned IDX_W   = idx_bits(FRAMES),
  localparam int unsigned ENTRY_W = LOG_ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ckpt_start,
  output logic               ckpt_busy,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_old_data,
  output logic               log_valid,
  input  logic               log_ready,
  output logic [ENTRY_W-1:0] log_entry
);
  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    logic [LOG_ADDR_W-1:0] a_ext;
    a_ext = LOG_ADDR_W'(a);
    return {a_ext, d};
  endfunction

  logic [IDX_W-1:0] frame_idx;
  logic             frame_hit;
  logic             fifo_full, fifo_empty;
  logic             req_accept, log_push, log_pop;

  assign frame_idx  = req_addr[OFF_W +: IDX_W];
  assign req_ready  = !ckpt_busy && !ckpt_start && (frame_hit || !fifo_full);
  assign req_accept = req_valid && req_ready;
  assign log_push   = req_accept && !frame_hit;
  assign log_valid  = !fifo_empty;
  assign log_pop    = log_valid && log_ready;

  ckpt_flag_array #(.FRAMES(FRAMES)) flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sweep_start(ckpt_start),
    .look_idx   (frame_idx),
    .mark       (log_push),
    .hit        (frame_hit),
    .sweep_busy (ckpt_busy)
  );

  ckpt_log_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (log_push),
    .wdata(pack_entry(req_addr, req_old_data)),
    .pop  (log_pop),
    .rdata(log_entry),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_ready) |=> (log_valid && $stable(log_entry)));

  // R8
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_push |=> log_valid);

  // R3
  repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && frame_hit && fifo_empty) |=> !log_valid);
endmodule

// File: tb/ckpt_undo_logger_tb_top.sv
`timescale 1ns/1ps
module ckpt_undo_logger_tb_top;
  localparam int AW = 16, DW = 32, NF = 8, DP = 4;
  localparam int EW = 64 + DW;

  logic clk = 0, rst_n = 0, ckpt_start = 0, req_valid = 0, log_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_old_data = '0;
  logic ckpt_busy, req_ready, log_valid;
  logic [EW-1:0] log_entry;

  always #2.5 clk = ~clk;

  ckpt_undo_logger #(.ADDR_W(AW), .DATA_W(DW), .BLOCK_BYTES(64), .FRAMES(NF), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ckpt_start(ckpt_start), .ckpt_busy(ckpt_busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_old_data(req_old_data), .log_valid(log_valid), .log_ready(log_ready),
    .log_entry(log_entry));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [EW-1:0] q [64];
  int qh = 0, qt = 0, mbusy = 0;
  bit mflag [NF];
  bit acc;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int f, input int up);
    return {7'(up), 3'(f), 6'h2A};
  endfunction

  function automatic int fidx(input logic [AW-1:0] a);
    return int'(a[8:6]);
  endfunction

  // one cycle: inputs already driven at negedge
  task automatic step();
    bit er;
    int occ;
    #1;
    occ = qt - qh;
    er = (mbusy == 0) && !ckpt_start && (mflag[fidx(req_addr)] || occ < DP);
    chk(req_ready == er, (mbusy > 0 || ckpt_start) ? "R5" : "R6", "req_ready",
        EW'(req_ready), EW'(er));
    chk(ckpt_busy == (mbusy > 0), "R5", "ckpt_busy", EW'(ckpt_busy), EW'(mbusy > 0));
    chk(log_valid == (occ > 0), "R8", "log_valid", EW'(log_valid), EW'(occ > 0));
    if (log_valid && log_ready && occ > 0) begin
      chk(log_entry == q[qh % 64], "R2", "log_entry", log_entry, q[qh % 64]);
      qh++;
    end
    acc = req_valid && req_ready;
    if (acc && !mflag[fidx(req_addr)]) begin
      q[qt % 64] = {48'h0, req_addr, req_old_data};
      qt++;
      mflag[fidx(req_addr)] = 1;
    end
    @(posedge clk);
    if (ckpt_start) begin
      mbusy = NF;
      for (int i = 0; i < NF; i++) mflag[i] = 0;
    end else if (mbusy > 0) mbusy--;
    @(negedge clk);
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_addr = a; req_old_data = d; req_valid = 1;
    for (int t = 0; t < 40; t++) begin
      step();
      if (acc) break;
      if (t > 2) log_ready = 1;
    end
    req_valid = 0;
  endtask

  task automatic checkpoint();
    ckpt_start = 1; step(); ckpt_start = 0;
    for (int i = 0; i < NF; i++) step();
  endtask

  initial begin
    for (int i = 0; i < NF; i++) mflag[i] = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1;
    chk(!log_valid, "R1", "log_valid in reset", EW'(log_valid), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!log_valid && !ckpt_busy && req_ready, "R1", "idle after reset",
        EW'({log_valid, ckpt_busy, req_ready}), EW'(3'b001));
    @(negedge clk);

    // Each frame once, then again in the same interval
    log_ready = 1;
    for (int f = 0; f < NF; f++) begin
      put(mk_addr(f, f + 1), 32'hC0DE0000 + 32'(f));
      #1; chk(log_valid == 1, "R9", "fresh frame logged", EW'(log_valid), 1);
      step();
      put(mk_addr(f, f + 40), 32'h5EED0000 + 32'(f));
      #1; chk(log_valid == 0, "R3", "repeat frame quiet", EW'(log_valid), 0);
      step();
    end

    // Checkpoint strobe with a request pending
    req_addr = mk_addr(2, 9); req_old_data = 32'hAAAA5555; req_valid = 1;
    ckpt_start = 1; #1;
    chk(req_ready == 0, "R5", "ready in start cycle", EW'(req_ready), 0);
    step(); ckpt_start = 0;
    for (int i = 0; i < NF; i++) begin
      #1; chk(ckpt_busy && !req_ready, "R5", "busy blocks", EW'({ckpt_busy, req_ready}), EW'(2'b10));
      step();
    end
    put(mk_addr(2, 9), 32'hAAAA5555);
    #1; chk(log_valid == 1, "R4", "relog after sweep", EW'(log_valid), 1);
    step();

    // Fill the FIFO with output stalled
    log_ready = 0;
    put(mk_addr(0, 3), 32'h11110000);
    put(mk_addr(1, 3), 32'h11110001);
    put(mk_addr(3, 3), 32'h11110003);
    put(mk_addr(4, 3), 32'h11110004);
    req_addr = mk_addr(5, 3); req_old_data = 32'h11110005; req_valid = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(req_ready == 0, "R6", "fresh frame stalled when full", EW'(req_ready), 0);
      chk(log_entry == q[qh % 64], "R7", "head held", log_entry, q[qh % 64]);
      step();
    end
    req_valid = 0;
    put(mk_addr(0, 77), 32'h22220000);
    #1; chk(acc == 1, "R6", "logged frame taken when full", EW'(acc), 1);
    log_ready = 1;
    put(mk_addr(5, 3), 32'h11110005);
    for (int i = 0; i < 8; i++) step();
    #1; chk(log_valid == 0 && qh == qt, "R7", "drained in order", EW'(log_valid), 0);

    // Strided sweep with a checkpoint in the middle and intermittent backpressure
    checkpoint();
    for (int k = 0; k < 40; k++) begin
      log_ready = (k % 3 != 0);
      if (k == 20) checkpoint();
      put(mk_addr((k * 3) % NF, k), 32'h9000_0000 ^ (32'(k) * 32'h01010101));
    end
    log_ready = 1;
    for (int i = 0; i < 8; i++) step();
    #1; chk(qh == qt && !log_valid, "R2", "all entries delivered", EW'(qt - qh), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule